// File: doc/BRIEF.md
# Burst Capture, Transform and Playback Sequencer

This block steers a burst measurement pipeline. On a start request it opens a capture window and writes a fixed-length block of converter samples into an input sample memory, one address per accepted sample. It then kicks a transform engine and waits for it to finish. The engine reads its operands from the input memory on its own. Its results arrive exactly once, so each one is written into a single-port result memory in the same cycle it is presented.

Once the transform engine reports that it has finished, the sequencer enters a playback phase. It reads the stored spectrum out to an output converter whenever that converter is ready, wrapping from the last address back to zero without end. A secondary reader may read the result memory through the same port, but only in playback cycles that the converter leaves free. A new start request during playback ends the loop after the word in flight and begins a fresh capture. A transform that never finishes trips a timeout, which sets an error flag and returns the sequencer to idle.

Top module: `burst_capture_sequencer`

## Requirements
- R1: After reset the sequencer is idle: `ready_o`, `err_o`, `in_we_o`, `res_re_o` and `fft_start_o` are 0. Samples are not written until `start_i` is seen high while idle, and in that same cycle `adc_start_o` is 1.
- R2: While capturing, every cycle with `adc_valid_i` high sets `in_we_o` in that cycle, with `in_addr_o` counting 0, 1, 2 and so on. Cycles without a sample leave `in_we_o` at 0.
- R3: In the cycle after the sample at address N-1 is written, `fft_start_o` is 1 for exactly one cycle.
- R4: After the start pulse the sequencer waits. It enters playback in the cycle after it first sees `fft_busy_i` low.
- R5: During the transform wait, `res_we_o` equals `fft_out_valid_i` in the same cycle, and `res_addr_o` counts 0, 1, 2 and so on over the written words.
- R6: In playback, each cycle with `dac_ready_i` high issues a result read (`res_re_o`=1) at addresses 0..N-1 that wrap to 0. `dac_valid_o` is 1 in the following cycle.
- R7: A secondary read (`rd_req_i`) is granted only in playback cycles with `dac_ready_i` low. In that cycle `rd_gnt_o`=1, `res_re_o`=1 and `res_addr_o`=`rd_addr_i`, and `rd_valid_o` is 1 in the next cycle. When `dac_ready_i` is high the converter takes the port and the playback address is unaffected.
- R8: `ready_o` is 1 in playback and 0 in every other state.
- R9: `start_i` during capture or during the transform wait has no effect: `adc_start_o` stays 0, the capture addresses continue, and playback follows as usual.
- R10: `start_i` during playback sets `adc_start_o`. The read issued in that cycle completes, and in the next cycle the sequencer is capturing from address 0 again.
- R11: If `fft_busy_i` is still high after TMO_CYCLES cycles of waiting, `err_o` is set and the sequencer returns to idle. `err_o` clears when the next capture is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture request |
| adc_start_o | output | 1 | Capture window opened (one cycle) |
| adc_valid_i | input | 1 | Converter sample present this cycle |
| in_we_o | output | 1 | Input memory write enable |
| in_addr_o | output | log2(N) | Input memory write address |
| fft_start_o | output | 1 | Transform kick pulse |
| fft_busy_i | input | 1 | Transform engine running |
| fft_out_valid_i | input | 1 | Transform result word present |
| dac_ready_i | input | 1 | Output converter wants a word |
| dac_valid_o | output | 1 | Result memory data now belongs to the converter |
| rd_req_i | input | 1 | Secondary reader request |
| rd_addr_i | input | log2(N) | Secondary reader address |
| rd_gnt_o | output | 1 | Secondary read issued this cycle |
| rd_valid_o | output | 1 | Result memory data now belongs to the secondary reader |
| res_we_o | output | 1 | Result memory write enable |
| res_re_o | output | 1 | Result memory read enable |
| res_addr_o | output | log2(N) | Result memory shared address |
| ready_o | output | 1 | Playback active |
| err_o | output | 1 | Transform timeout seen |

## Verification
Several rules are checked by the assertions on every cycle. The capture address steps by one on each write, and the kick follows the last write. A result write never happens without a valid word. The reader is never granted while the converter wants the port, and each read returns valid data one cycle later. The error and ready flags never coincide. The directed scenarios are needed for the rest: the exact address sequences, the wrap in playback, and the ignored start requests during capture and transform. They also cover the restart from playback and the timeout window boundary, since those depend on input history.

// File: rtl/cps_pkg.sv
package cps_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FILL  = 3'd1,
      ST_KICK  = 3'd2,
      ST_XFORM = 3'd3,
      ST_PLAY  = 3'd4
   } cps_state_e;
endpackage

// File: rtl/cps_counter.sv
module cps_counter #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic         at_max
);
   // power-of-two depth: natural overflow gives the wrap (R6)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end
   assign at_max = &cnt;
endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
   import cps_pkg::*;
#(
   parameter int TMO_CYCLES = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       fill_last_i,
   input  logic       fft_busy_i,
   output cps_state_e state_o,
   output logic       start_ok_o,
   output logic       err_o
);
   localparam int TW = $clog2(TMO_CYCLES + 2);

   cps_state_e state, nxt;
   logic       expired;

   // R1, R9, R10: start honoured only when idle or playing
   assign start_ok_o = start_i && (state == ST_IDLE || state == ST_PLAY);

   generate
      if (TMO_CYCLES > 0) begin : g_tmo
         logic [TW-1:0] tmr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 tmr <= '0;
            else if (state != ST_XFORM) tmr <= '0;
            else if (fft_busy_i)        tmr <= tmr + 1'b1;
         end
         // R11
         assign expired = (state == ST_XFORM) && fft_busy_i &&
                          (tmr == TW'(TMO_CYCLES - 1));
      end else begin : g_no_tmo
         assign expired = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:  if (start_ok_o) nxt = ST_FILL;
         ST_FILL:  if (fill_last_i) nxt = ST_KICK;        // R3
         ST_KICK:  nxt = ST_XFORM;
         ST_XFORM: begin
            if (!fft_busy_i)  nxt = ST_PLAY;              // R4
            else if (expired) nxt = ST_IDLE;              // R11
         end
         ST_PLAY:  if (start_ok_o) nxt = ST_FILL;         // R10
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          err_o <= 1'b0;
      else if (start_ok_o) err_o <= 1'b0;
      else if (expired)    err_o <= 1'b1;
   end

   assign state_o = state;
endmodule

// File: rtl/cps_port_arb.sv
module cps_port_arb
   import cps_pkg::*;
#(
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  cps_state_e    state_i,
   input  logic          fft_out_valid_i,
   input  logic          dac_ready_i,
   input  logic          rd_req_i,
   input  logic [AW-1:0] rd_addr_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [AW-1:0] paddr_i,
   output logic          res_we_o,
   output logic          res_re_o,
   output logic [AW-1:0] res_addr_o,
   output logic          play_rd_o,
   output logic          rd_gnt_o,
   output logic          rd_valid_o,
   output logic          dac_valid_o
);
   logic in_play;
   assign in_play   = (state_i == ST_PLAY);
   assign play_rd_o = in_play && dac_ready_i;             // R6
   assign rd_gnt_o  = in_play && rd_req_i && !dac_ready_i; // R7 converter first
   assign res_we_o  = (state_i == ST_XFORM) && fft_out_valid_i; // R5
   assign res_re_o  = play_rd_o || rd_gnt_o;

   always_comb begin
      if (res_we_o)      res_addr_o = waddr_i;
      else if (rd_gnt_o) res_addr_o = rd_addr_i;
      else               res_addr_o = paddr_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_valid_o <= 1'b0;
         rd_valid_o  <= 1'b0;
      end else begin
         dac_valid_o <= play_rd_o;
         rd_valid_o  <= rd_gnt_o;
      end
   end
endmodule

// File: rtl/burst_capture_sequencer.sv
module burst_capture_sequencer
   import cps_pkg::*;
#(
   parameter int N          = 256,
   parameter int TMO_CYCLES = 4096,
   parameter int AW         = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic          adc_start_o,
   input  logic          adc_valid_i,
   output logic          in_we_o,
   output logic [AW-1:0] in_addr_o,
   output logic          fft_start_o,
   input  logic          fft_busy_i,
   input  logic          fft_out_valid_i,
   input  logic          dac_ready_i,
   output logic          dac_valid_o,
   input  logic          rd_req_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic          rd_gnt_o,
   output logic          rd_valid_o,
   output logic          res_we_o,
   output logic          res_re_o,
   output logic [AW-1:0] res_addr_o,
   output logic          ready_o,
   output logic          err_o
);
   generate
      if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
         $error("N must be a power of two, at least 2");
      end
      if (AW != $clog2(N)) begin : g_bad_aw
         $error("AW must equal clog2(N)");
      end
      if (TMO_CYCLES < 0) begin : g_bad_tmo
         $error("TMO_CYCLES must not be negative");
      end
   endgenerate

   cps_state_e    state;
   logic          start_ok, fill_last, cap_max, play_rd;
   logic          wr_max, pl_max;
   logic [AW-1:0] waddr, paddr;

   assign in_we_o     = (state == ST_FILL) && adc_valid_i;   // R2
   assign fill_last   = in_we_o && cap_max;
   assign adc_start_o = start_ok;
   assign fft_start_o = (state == ST_KICK);                  // R3
   assign ready_o     = (state == ST_PLAY);                  // R8

   cps_fsm #(.TMO_CYCLES(TMO_CYCLES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .fill_last_i(fill_last),
      .fft_busy_i(fft_busy_i), .state_o(state), .start_ok_o(start_ok),
      .err_o(err_o)
   );

   cps_counter #(.W(AW)) u_cap_cnt (
      .clk(clk), .rst_n(rst_n), .clr(state != ST_FILL), .inc(in_we_o),
      .cnt(in_addr_o), .at_max(cap_max)
   );

   cps_counter #(.W(AW)) u_wr_cnt (
      .clk(clk), .rst_n(rst_n), .clr(state != ST_XFORM), .inc(res_we_o),
      .cnt(waddr), .at_max(wr_max)
   );

   cps_counter #(.W(AW)) u_play_cnt (
      .clk(clk), .rst_n(rst_n), .clr(state != ST_PLAY), .inc(play_rd),
      .cnt(paddr), .at_max(pl_max)
   );

   cps_port_arb #(.AW(AW)) u_arb (
      .clk(clk), .rst_n(rst_n), .state_i(state),
      .fft_out_valid_i(fft_out_valid_i), .dac_ready_i(dac_ready_i),
      .rd_req_i(rd_req_i), .rd_addr_i(rd_addr_i), .waddr_i(waddr),
      .paddr_i(paddr), .res_we_o(res_we_o), .res_re_o(res_re_o),
      .res_addr_o(res_addr_o), .play_rd_o(play_rd), .rd_gnt_o(rd_gnt_o),
      .rd_valid_o(rd_valid_o), .dac_valid_o(dac_valid_o)
   );
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
   parameter int AW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_we_o,
   input logic [AW-1:0] in_addr_o,
   input logic          fft_start_o,
   input logic          fft_out_valid_i,
   input logic          dac_ready_i,
   input logic          dac_valid_o,
   input logic          rd_gnt_o,
   input logic          rd_valid_o,
   input logic          res_we_o,
   input logic          res_re_o,
   input logic          ready_o,
   input logic          err_o
);
   localparam logic [AW-1:0] LAST = '1;

   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      in_we_o && in_addr_o != LAST |=> !in_we_o || in_addr_o == $past(in_addr_o) + 1'b1);

   a_r3_kick_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      in_we_o && in_addr_o == LAST |=> fft_start_o);

   a_r3_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
      fft_start_o |=> !fft_start_o);

   a_r5_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      res_we_o |-> fft_out_valid_i);

   a_r6_play_returns: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o && res_re_o && !rd_gnt_o |=> dac_valid_o);

   a_r7_dac_priority: assert property (@(posedge clk) disable iff (!rst_n)
      dac_ready_i |-> !rd_gnt_o);

   a_r7_reader_returns: assert property (@(posedge clk) disable iff (!rst_n)
      rd_gnt_o |=> rd_valid_o && !dac_valid_o);

   a_r8_ready_err_apart: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !ready_o);
endmodule

bind burst_capture_sequencer cps_checker #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_we_o(in_we_o), .in_addr_o(in_addr_o),
   .fft_start_o(fft_start_o), .fft_out_valid_i(fft_out_valid_i),
   .dac_ready_i(dac_ready_i), .dac_valid_o(dac_valid_o), .rd_gnt_o(rd_gnt_o),
   .rd_valid_o(rd_valid_o), .res_we_o(res_we_o), .res_re_o(res_re_o),
   .ready_o(ready_o), .err_o(err_o)
);

// File: tb/tb_burst_capture_sequencer.sv
module tb_burst_capture_sequencer;
   localparam int N   = 8;
   localparam int TMO = 40;
   localparam int AW  = 3;

   logic clk = 0, rst_n = 0;
   logic start_i = 0, adc_valid_i = 0, fft_busy_i = 0, fft_out_valid_i = 0;
   logic dac_ready_i = 0, rd_req_i = 0;
   logic [AW-1:0] rd_addr_i = '0;
   logic adc_start_o, in_we_o, fft_start_o, dac_valid_o, rd_gnt_o, rd_valid_o;
   logic res_we_o, res_re_o, ready_o, err_o;
   logic [AW-1:0] in_addr_o, res_addr_o;
   int nchk = 0, nerr = 0;

   always #5 clk = ~clk;

   burst_capture_sequencer #(.N(N), .TMO_CYCLES(TMO)) dut (.*);

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", ready_o, 0);
      chk("R1 err in reset", err_o, 0);
      chk("R1 in_we in reset", in_we_o, 0);
      chk("R1 res_re in reset", res_re_o, 0);
      chk("R1 fft_start in reset", fft_start_o, 0);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic t_idle_wait;
      adc_valid_i = 1;
      for (int i = 0; i < 5; i++) begin
         #1 chk("R1 no write while idle", in_we_o, 0);
         chk("R1 idle not ready", ready_o, 0);
         @(negedge clk);
      end
      adc_valid_i = 0;
   endtask

   task automatic t_begin_capture;
      start_i = 1;
      #1 chk("R1 adc_start on start", adc_start_o, 1);
      @(negedge clk);
      start_i = 0;
   endtask

   task automatic t_samples(input bit gaps, input bit poke_start);
      for (int k = 0; k < N; k++) begin
         if (gaps && k % 3 == 1) begin
            adc_valid_i = 0;
            #1 chk("R2 no write without sample", in_we_o, 0);
            @(negedge clk);
         end
         adc_valid_i = 1;
         start_i = poke_start && k == 3;
         #1 chk("R2 in_we", in_we_o, 1);
         chk("R2 in_addr", in_addr_o, k);
         if (poke_start && k == 3) chk("R9 start ignored in fill", adc_start_o, 0);
         @(negedge clk);
      end
      adc_valid_i = 0;
      start_i = 0;
      #1 chk("R3 kick after last", fft_start_o, 1);
      chk("R3 no write after last", in_we_o, 0);
      @(negedge clk);
      #1 chk("R3 kick single", fft_start_o, 0);
   endtask

   task automatic t_xform(input bit poke_start);
      fft_busy_i = 1;
      @(negedge clk);
      for (int k = 0; k < N; k++) begin
         fft_out_valid_i = 1;
         start_i = poke_start && k == 2;
         #1 chk("R5 res_we with valid", res_we_o, 1);
         chk("R5 res_addr", res_addr_o, k);
         chk("R8 not ready in transform", ready_o, 0);
         if (poke_start && k == 2) chk("R9 start ignored in transform", adc_start_o, 0);
         @(negedge clk);
         fft_out_valid_i = 0;
         start_i = 0;
         if (k % 2 == 0) begin
            #1 chk("R5 no write without valid", res_we_o, 0);
            @(negedge clk);
         end
      end
      fft_busy_i = 0;
      #1 chk("R4 wait while busy seen", ready_o, 0);
      @(negedge clk);
      #1 chk("R4 playback after busy drop", ready_o, 1);
      chk("R11 no error", err_o, 0);
   endtask

   task automatic t_play;
      dac_ready_i = 1;
      for (int k = 0; k < N + 3; k++) begin
         #1 chk("R6 play read", res_re_o, 1);
         chk("R6 play addr wraps", res_addr_o, k % N);
         @(negedge clk);
         chk("R6 dac_valid next cycle", dac_valid_o, 1);
      end
      dac_ready_i = 0;
      #1 chk("R6 idle port", res_re_o, 0);
      @(negedge clk);
      chk("R6 no dac_valid", dac_valid_o, 0);
   endtask

   task automatic t_reader;
      rd_req_i = 1;
      rd_addr_i = 3'd5;
      #1 chk("R7 grant in free cycle", rd_gnt_o, 1);
      chk("R7 reader addr", res_addr_o, 5);
      chk("R7 read enable", res_re_o, 1);
      @(negedge clk);
      chk("R7 rd_valid next cycle", rd_valid_o, 1);
      dac_ready_i = 1;
      #1 chk("R7 converter wins", rd_gnt_o, 0);
      chk("R7 play addr kept", res_addr_o, 3);
      @(negedge clk);
      chk("R7 no rd_valid after loss", rd_valid_o, 0);
      chk("R7 dac_valid after win", dac_valid_o, 1);
      rd_req_i = 0;
      dac_ready_i = 0;
   endtask

   task automatic t_restart;
      dac_ready_i = 1;
      start_i = 1;
      #1 chk("R10 adc_start in playback", adc_start_o, 1);
      chk("R10 word in flight issued", res_re_o, 1);
      @(negedge clk);
      start_i = 0;
      dac_ready_i = 0;
      chk("R10 word completes", dac_valid_o, 1);
      #1 chk("R10 playback ended", ready_o, 0);
      chk("R10 no read after restart", res_re_o, 0);
   endtask

   task automatic t_timeout;
      fft_busy_i = 1;
      repeat (30) @(negedge clk);
      #1 chk("R11 no error before window", err_o, 0);
      repeat (15) @(negedge clk);
      #1 chk("R11 error after window", err_o, 1);
      chk("R11 not ready", ready_o, 0);
      fft_busy_i = 0;
      @(negedge clk);
      #1 chk("R11 back to idle", ready_o, 0);
      t_begin_capture();
      #1 chk("R11 error cleared by start", err_o, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
   end

   initial begin
      t_reset();
      t_idle_wait();
      t_begin_capture();
      t_samples(1'b1, 1'b0);
      t_xform(1'b0);
      t_play();
      t_reader();
      t_restart();
      t_samples(1'b0, 1'b1);
      t_xform(1'b1);
      t_samples_check_idle();
      report();
      $finish;
   end

   task automatic t_samples_check_idle;
      t_restart();
      t_samples(1'b0, 1'b0);
      t_timeout();
   endtask
endmodule